// File: doc/BRIEF.md
# Partitioned SIMD Rounding Halving Adder

This block averages two unsigned vectors lane by lane. The two 128-bit operands are cut into independent lanes of 8, 16 or 32 bits, according to a two-bit lane-size code. Each lane adds its two elements, adds an optional rounding one, and halves the result. The adder keeps the carry out of the lane, so no information is lost before the halving. A width-select bit chooses whether the low 64 bits or all 128 bits are active. A mode input chooses between the rounded-up average and the truncated average.

The block sits inside a vector execution pipeline. An operation is launched by raising `in_valid` with the operands and controls. By default the result appears one clock later on a registered output. Setting the parameter `REG_OUT` to 0 removes that register and makes the path purely combinational. The lane-size code 3 is reserved. It raises an undefined-operation flag, and the block produces no valid result for it.

Top module: `simd_avg_unit`

## Requirements
- R1: With `trunc_mode`=0, every active lane result equals (a + b + 1) >> 1. The sum is computed on the unsigned lane values, and the low lane-width bits are kept.
- R2: With `trunc_mode`=1, every active lane result equals (a + b) >> 1, with the same unsigned arithmetic as R1.
- R3: The lane width is 8 << `lane_size`: code 0 gives 8-bit lanes, 1 gives 16-bit lanes and 2 gives 32-bit lanes. Lane e occupies bits [e*width +: width] of both operands and of the result.
- R4: No carry crosses a lane boundary. Two all-ones operands give an all-ones result in every active lane, for every size and mode.
- R5: With `wide_sel`=0, only bits [63:0] are active and result bits [127:64] are zero. With `wide_sel`=1, all 128 bits are active.
- R6: For an accepted operation with `lane_size`=3, the following cycle shows `undef_op`=1, `res_valid`=0 and a result of zero.
- R7: With `REG_OUT`=1, the outputs appear one clock after the operation is sampled. `res_valid` is 1 exactly when `in_valid` was 1 and the size code was legal.
- R8: While reset is active, and right after it, `res_valid`=0, `undef_op`=0 and `res_data`=0.
- R9: A cycle with `in_valid`=0 leaves `res_data` unchanged and drives `res_valid` and `undef_op` to 0, whatever the operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Launches an operation this cycle |
| opnd_a | input | 128 | First operand vector |
| opnd_b | input | 128 | Second operand vector |
| lane_size | input | 2 | Lane-size code (0: 8-bit, 1: 16-bit, 2: 32-bit, 3: reserved) |
| wide_sel | input | 1 | 0: 64-bit active width, 1: 128-bit active width |
| trunc_mode | input | 1 | 0: rounded average, 1: truncated average |
| res_data | output | 128 | Packed lane results |
| res_valid | output | 1 | Result is valid |
| undef_op | output | 1 | Reserved size code was used |

## Verification
The lane averages are driven with all-zero and all-ones operands, with the complementary alternating patterns 0xAA/0x55, and with random words, for every legal combination of size, width and mode.

- All-ones operands expose any carry that leaks across a lane boundary, and any loss of the lane carry-out.
- The alternating patterns sum to all-ones in every lane, so they separate the rounding mode from the truncating one at the top bit of each lane.
- Random words exercise lane placement.
- Reserved-size and idle cycles check that the flag is raised and that the held data is not disturbed.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;

   localparam int unsigned VEC_BITS  = 128;
   localparam int unsigned HALF_BITS = VEC_BITS / 2;
   localparam int unsigned NUM_SIZES = 3;

   typedef enum logic [1:0] {
      LSZ_B8  = 2'd0,
      LSZ_B16 = 2'd1,
      LSZ_B32 = 2'd2,
      LSZ_RSV = 2'd3
   } lane_size_e;

   function automatic int unsigned lane_bits(input int unsigned code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/simd_avg_lane.sv
module simd_avg_lane #(
   parameter int unsigned ESIZE = 8
) (
   input  logic [ESIZE-1:0] elem_a,
   input  logic [ESIZE-1:0] elem_b,
   input  logic             round_in,
   output logic [ESIZE-1:0] elem_avg
);
   localparam int unsigned SUM_W = ESIZE + 1;

   logic [SUM_W-1:0] lane_sum;

   if (ESIZE < 2) begin : g_bad_width
      $error("simd_avg_lane: ESIZE must be at least 2");
   end

   // The extra bit keeps the carry out; after the halving it becomes the lane MSB.
   always_comb begin
      lane_sum = {1'b0, elem_a} + {1'b0, elem_b} + {{ESIZE{1'b0}}, round_in};
      elem_avg = lane_sum[SUM_W-1:1];
   end

endmodule

// File: rtl/simd_avg_bank.sv
module simd_avg_bank #(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned ESIZE = 8
) (
   input  logic [VEC_W-1:0] vec_a,
   input  logic [VEC_W-1:0] vec_b,
   input  logic             round_in,
   output logic [VEC_W-1:0] vec_avg
);
   localparam int unsigned NLANE = VEC_W / ESIZE;

   if (VEC_W % ESIZE != 0) begin : g_bad_split
      $error("simd_avg_bank: VEC_W must be a multiple of ESIZE");
   end

   for (genvar e = 0; e < NLANE; e++) begin : g_lane
      simd_avg_lane #(.ESIZE(ESIZE)) u_lane (
         .elem_a   (vec_a[e*ESIZE +: ESIZE]),
         .elem_b   (vec_b[e*ESIZE +: ESIZE]),
         .round_in (round_in),
         .elem_avg (vec_avg[e*ESIZE +: ESIZE])
      );
   end

endmodule

// File: rtl/simd_avg_select.sv
module simd_avg_select
   import simd_avg_pkg::*;
#(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned NSIZES = 3
) (
   input  logic [NSIZES-1:0][VEC_W-1:0] bank_res,
   input  logic [1:0]                   size_code,
   input  logic                         wide_sel,
   output logic [VEC_W-1:0]             sel_res,
   output logic                         is_undef
);
   localparam int unsigned HALF_W = VEC_W / 2;

   logic [VEC_W-1:0] picked;

   always_comb begin
      is_undef = 1'b0;
      picked   = '0;
      unique case (lane_size_e'(size_code))
         LSZ_B8:  picked = bank_res[0];
         LSZ_B16: picked = bank_res[1];
         LSZ_B32: picked = bank_res[2];
         default: is_undef = 1'b1;
      endcase
      sel_res = wide_sel ? picked : {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
   end

endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
   import simd_avg_pkg::*;
#(
   parameter int unsigned VEC_W   = 128,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] opnd_a,
   input  logic [VEC_W-1:0] opnd_b,
   input  logic [1:0]       lane_size,
   input  logic             wide_sel,
   input  logic             trunc_mode,
   output logic [VEC_W-1:0] res_data,
   output logic             res_valid,
   output logic             undef_op
);
   localparam int unsigned NSIZES = NUM_SIZES;
   localparam int unsigned MAX_E  = lane_bits(NSIZES - 1);

   if (VEC_W != VEC_BITS) begin : g_bad_vec
      $error("simd_avg_unit: VEC_W must be 128");
   end
   if (VEC_W % (2 * MAX_E) != 0) begin : g_bad_half
      $error("simd_avg_unit: half width must hold whole widest lanes");
   end

   logic [NSIZES-1:0][VEC_W-1:0] bank_res;
   logic [VEC_W-1:0]             comb_res;
   logic                         comb_undef;
   logic                         round_in;

   assign round_in = ~trunc_mode;

   for (genvar k = 0; k < NSIZES; k++) begin : g_bank
      simd_avg_bank #(.VEC_W(VEC_W), .ESIZE(lane_bits(k))) u_bank (
         .vec_a    (opnd_a),
         .vec_b    (opnd_b),
         .round_in (round_in),
         .vec_avg  (bank_res[k])
      );
   end

   simd_avg_select #(.VEC_W(VEC_W), .NSIZES(NSIZES)) u_sel (
      .bank_res  (bank_res),
      .size_code (lane_size),
      .wide_sel  (wide_sel),
      .sel_res   (comb_res),
      .is_undef  (comb_undef)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_data  <= '0;
            res_valid <= 1'b0;
            undef_op  <= 1'b0;
         end else if (in_valid) begin
            res_data  <= comb_res;
            res_valid <= ~comb_undef;
            undef_op  <= comb_undef;
         end else begin
            res_valid <= 1'b0;
            undef_op  <= 1'b0;
         end
      end
   end else begin : g_comb
      always_comb begin
         res_data  = comb_res;
         res_valid = in_valid & ~comb_undef;
         undef_op  = in_valid & comb_undef;
      end
   end

endmodule

// File: rtl/simd_avg_unit_chk.sv
module simd_avg_unit_chk #(
   parameter int unsigned VEC_W   = 128,
   parameter bit          REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [VEC_W-1:0] opnd_a,
   input logic [VEC_W-1:0] opnd_b,
   input logic [1:0]       lane_size,
   input logic             wide_sel,
   input logic [VEC_W-1:0] res_data,
   input logic             res_valid,
   input logic             undef_op
);
   localparam int unsigned HALF_W = VEC_W / 2;

   always_comb begin
      if (rst_n) begin
         assert_valid_not_undef_R6: assert (!(res_valid && undef_op))
            else $error("valid and undefined raised together");
      end
   end

   if (REG_OUT) begin : g_seq
      assert_undef_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && lane_size == 2'd3) |=> (undef_op && !res_valid && res_data == '0));

      assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && lane_size != 2'd3) |=> res_valid);

      assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!res_valid && !undef_op && $stable(res_data)));

      assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !wide_sel) |=> (res_data[VEC_W-1:HALF_W] == '0));

      assert_no_lane_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && wide_sel && lane_size != 2'd3 && opnd_a == '1 && opnd_b == '1)
         |=> (res_data == '1));
   end

endmodule

bind simd_avg_unit simd_avg_unit_chk #(.VEC_W(VEC_W), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .lane_size (lane_size),
   .wide_sel  (wide_sel),
   .res_data  (res_data),
   .res_valid (res_valid),
   .undef_op  (undef_op)
);

// File: tb/simd_avg_unit_bench.sv
`timescale 1ns/1ps
module simd_avg_unit_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] opnd_a = '0;
   logic [127:0] opnd_b = '0;
   logic [1:0]   lane_size = 2'd0;
   logic         wide_sel = 1'b0;
   logic         trunc_mode = 1'b0;
   logic [127:0] res_data;
   logic         res_valid;
   logic         undef_op;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   simd_avg_unit u_simd_avg_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .opnd_a     (opnd_a),
      .opnd_b     (opnd_b),
      .lane_size  (lane_size),
      .wide_sel   (wide_sel),
      .trunc_mode (trunc_mode),
      .res_data   (res_data),
      .res_valid  (res_valid),
      .undef_op   (undef_op)
   );

   function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                          input int sz, input bit q, input bit tr);
      logic [127:0] r = '0;
      int esize, width;
      longint unsigned mask, x, y, s;
      if (sz == 3) return '0;
      esize = 8 << sz;
      width = q ? 128 : 64;
      mask  = (64'd1 << esize) - 1;
      for (int e = 0; e < width / esize; e++) begin
         x = 64'((a >> (e * esize))) & mask;
         y = 64'((b >> (e * esize))) & mask;
         s = ((x + y + (tr ? 0 : 1)) >> 1) & mask;
         r = r | (128'(s) << (e * esize));
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive at the falling edge, sample 1 ns after the next rising edge
   task automatic apply(input bit v, input logic [127:0] a, input logic [127:0] b,
                        input int sz, input bit q, input bit tr, input string tag);
      logic [127:0] prev;
      @(negedge clk);
      prev = res_data;
      in_valid = v; opnd_a = a; opnd_b = b;
      lane_size = 2'(sz); wide_sel = q; trunc_mode = tr;
      @(posedge clk);
      #1;
      if (v) begin
         check({tag, " data"}, res_data, model(a, b, sz, q, tr));
         check("R7 valid", 128'(res_valid), 128'(sz != 3));
         check("R6 undef", 128'(undef_op), 128'(sz == 3));
      end else begin
         check("R9 data held", res_data, prev);
         check("R9 valid low", 128'(res_valid), 128'd0);
         check("R9 undef low", 128'(undef_op), 128'd0);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [127:0] alt_a, alt_b;
      alt_a = {16{8'hAA}};
      alt_b = {16{8'h55}};
      repeat (3) @(posedge clk);
      #1;
      check("R8 reset data", res_data, '0);
      check("R8 reset valid", 128'(res_valid), '0);
      check("R8 reset undef", 128'(undef_op), '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R8 after reset valid", 128'(res_valid), '0);

      for (int sz = 0; sz < 3; sz++) begin
         for (int q = 0; q < 2; q++) begin
            for (int tr = 0; tr < 2; tr++) begin
               apply(1, '0, '0, sz, q[0], tr[0], "R1/R2 zeros");
               apply(1, '1, '1, sz, q[0], tr[0], "R4 all-ones");
               if (q == 1) check("R4 full ones", res_data, '1);
               else        check("R5 upper zero", {64'd0, res_data[127:64]}, '0);
               apply(1, alt_a, alt_b, sz, q[0], tr[0], tr ? "R2 alternating" : "R1 alternating");
               for (int k = 0; k < 8; k++) begin
                  apply(1, {$urandom, $urandom, $urandom, $urandom},
                        {$urandom, $urandom, $urandom, $urandom},
                        sz, q[0], tr[0], "R3 random");
               end
            end
         end
      end

      // R1: rounded 16-bit lanes, 0x0001 + 0x0002 rounds up to 0x0002
      apply(1, 128'h0001, 128'h0002, 1, 1'b1, 1'b0, "R1 round up");
      check("R1 explicit", res_data, 128'h0002);
      // R2: the same operands truncate to 0x0001
      apply(1, 128'h0001, 128'h0002, 1, 1'b1, 1'b1, "R2 truncate");
      check("R2 explicit", res_data, 128'h0001);
      // R3: 32-bit lane 1 sits at bits [63:32]
      apply(1, 128'h0000_0010_0000_0000, 128'h0000_0020_0000_0000, 2, 1'b0, 1'b0, "R3 lane pos");
      check("R3 explicit", res_data, 128'h0000_0018_0000_0000);
      // R6: reserved size code
      apply(1, '1, 128'h1234, 3, 1'b1, 1'b0, "R6 reserved");
      check("R6 zero data", res_data, '0);
      // R9: an idle cycle with new operands leaves everything held
      apply(1, alt_a, alt_a, 0, 1'b1, 1'b0, "R1 before idle");
      apply(0, '1, '0, 2, 1'b1, 1'b1, "R9 idle");
      apply(0, '0, '1, 3, 1'b0, 1'b0, "R9 idle reserved");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule